// File: doc/BRIEF.md
# Dual-Event Timer Input Capture

This block watches an external event line in the timer clock domain and stores the value of a free-running counter when that line shows an edge of the selected polarity. The counter is an input; this block does not count. The first qualifying event fills capture slot 0. If second-event capture is enabled, the next qualifying event fills capture slot 1. After the last enabled slot is filled, every further event is ignored until software rearms the block.

Software works from a bus clock that is asynchronous to the timer clock. An arm pulse loads the edge selection and the second-event enable, and rearms both slots. Each captured value crosses to the bus domain through a toggle handshake. The bus-side copy therefore changes only on a synchronised arrival, and never while a read is using it. Reads use a 16-bit port. Software reads the low half of a slot first, and that read also latches the upper half into a shadow register. The high-half read that follows returns the shadow, so the two halves always belong to the same 32-bit capture.

Assumptions: the timer clock is no faster than the bus clock. Arm pulses are at least several timer cycles apart.

Top module: `dual_capture_timer`

## Requirements
- R1: After reset, both capture values, the read data, the read shadow and both done flags are zero.
- R2: Events are ignored before the first arm pulse, and also when the armed edge selection is 00.
- R3: Edge selection 01 captures only on rising edges of the event input.
- R4: Edge selection 10 captures only on falling edges of the event input.
- R5: Edge selection 11 captures on both rising and falling edges.
- R6: The first qualifying event after an arm pulse stores into slot 0 the counter value present at the third rising timer-clock edge after the event input changes.
- R7: If second-event capture was armed with a 1, the next qualifying event stores the counter into slot 1. If it was armed with a 0, slot 1 keeps its value.
- R8: Once the last enabled slot is filled, further events change neither slot until the next arm pulse.
- R9: cap_done bit k (bit 0 for slot 0, bit 1 for slot 1) goes high when slot k's new value is readable on the bus side. An arm pulse clears both bits, and the arm pulse wins over an arrival in the same cycle.
- R10: A read with rd_en=1 selects a slot with rd_slot (0 or 1) and a half with rd_hi (0 for bits 15:0). rd_data carries the result one bus cycle later.
- R11: A high-half read (rd_hi=1) returns bits 31:16 of the slot value as it was at the most recent low-half read, even if a newer capture has arrived since then.
- R12: The bus-side copy of a slot changes only on a synchronised arrival from the timer domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tmr_clk | input | 1 | Timer clock |
| tmr_rst_n | input | 1 | Synchronous active-low reset, timer domain |
| cnt_val | input | 32 | Running counter value, timer domain |
| evt_in | input | 1 | Asynchronous external event line |
| bus_clk | input | 1 | Bus clock, asynchronous to tmr_clk |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain |
| arm | input | 1 | One-cycle pulse that loads the configuration and rearms both slots |
| arm_edge_sel | input | 2 | Edge selection taken at arm: 00 none, 01 rise, 10 fall, 11 both |
| arm_second | input | 1 | Second-event capture enable taken at arm |
| rd_en | input | 1 | Read strobe |
| rd_slot | input | 1 | Slot to read |
| rd_hi | input | 1 | 0 for the low half, 1 for the high half |
| rd_data | output | 16 | Read result, one cycle after rd_en |
| cap_done | output | 2 | Per-slot flag: a new value is readable |

## Verification
The checker watches several rules on every cycle. It confirms that the timer-side slots hold still once filled, that an unarmed block stays idle, and that the bus-side copies and the read shadow change only on an arrival or on a low-half read. It also confirms that done flags rise only after an arrival and clear after an arm pulse. The bench scenarios cover the rest. They show that each edge polarity captures the right counter value at the right cycle, how the second slot behaves, and that a high-half read stays coherent when a new capture lands between the two halves.

// File: rtl/dct_pkg.sv
// Shared types for the dual-event capture block.
// Assumes: two capture slots; edge selection encoded as a 2-bit field.
package dct_pkg;
    localparam int NUM_SLOTS = 2;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'b00,
        SLOT_WAIT1 = 2'b01,
        SLOT_WAIT2 = 2'b10,
        SLOT_DONE  = 2'b11
    } slot_state_e;
endpackage

// File: rtl/dct_sync2.sv
// Two-flop synchroniser for a bundle of independent single-bit signals.
// Assumes: each bit is a level or toggle signal that crosses domains on its own.
module dct_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two flops in series resolve metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/dct_edge_detect.sv
// Synchronises the event line and flags edges of the selected polarity.
// Assumes: the event line is asynchronous; hit is combinational from registered state.
module dct_edge_detect
    import dct_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      evt_in,
    input  edge_sel_e sel,
    output logic      hit
);
    logic evt_s;
    logic evt_prev;
    logic [1:0] sel_bits;

    dct_sync2 #(.W(1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (evt_in),
        .q     (evt_s)
    );

    // Remember the previous synchronised level so that edges can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_prev <= 1'b0;
        else        evt_prev <= evt_s;
    end

    // Qualify each edge direction with its select bit.
    always_comb begin
        sel_bits = sel;
        hit = (sel_bits[0] & evt_s & ~evt_prev) | (sel_bits[1] & ~evt_s & evt_prev);
    end
endmodule

// File: rtl/dct_capture_ctrl.sv
// Timer-domain slot sequencer: fills slot 0, then slot 1 if enabled, then locks.
// Assumes: arm config is stable on the bus side when the arm toggle is synchronised.
module dct_capture_ctrl
    import dct_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           hit,
    input  logic [CNT_W-1:0]               cnt_val,
    input  logic                           arm_tgl_s,
    input  edge_sel_e                      arm_sel,
    input  logic                           arm_second,
    output edge_sel_e                      sel_q,
    output slot_state_e                    state_q,
    output logic                           arm_edge,
    output logic [NUM_SLOTS-1:0]           cap_tgl,
    output logic [NUM_SLOTS-1:0][CNT_W-1:0] cap_val
);
    logic arm_prev;
    logic second_q;

    assign arm_edge = arm_tgl_s ^ arm_prev;

    // Rearm on a synchronised arm toggle; otherwise store the counter on each qualifying hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_prev <= 1'b0;
            sel_q    <= EDGE_NONE;
            second_q <= 1'b0;
            state_q  <= SLOT_IDLE;
            cap_tgl  <= '0;
            cap_val  <= '0;
        end else begin
            arm_prev <= arm_tgl_s;
            if (arm_edge) begin
                sel_q    <= arm_sel;
                second_q <= arm_second;
                state_q  <= SLOT_WAIT1;
            end else if (hit) begin
                case (state_q)
                    SLOT_WAIT1: begin
                        cap_val[0] <= cnt_val;
                        cap_tgl[0] <= ~cap_tgl[0];
                        state_q    <= second_q ? SLOT_WAIT2 : SLOT_DONE;
                    end
                    SLOT_WAIT2: begin
                        cap_val[1] <= cnt_val;
                        cap_tgl[1] <= ~cap_tgl[1];
                        state_q    <= SLOT_DONE;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dct_bus_regs.sv
// Bus-domain side: arm config, per-slot copies taken on arrival, split 16-bit reads.
// Assumes: timer-side slot values are stable while their toggle is being synchronised.
module dct_bus_regs
    import dct_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int HALF_W = CNT_W / 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            arm,
    input  logic [1:0]                      arm_sel_in,
    input  logic                            arm_second_in,
    output edge_sel_e                       cfg_sel,
    output logic                            cfg_second,
    output logic                            arm_tgl,
    input  logic [NUM_SLOTS-1:0]            tgl_s,
    input  logic [NUM_SLOTS-1:0][CNT_W-1:0] cap_t,
    input  logic                            rd_en,
    input  logic                            rd_slot,
    input  logic                            rd_hi,
    output logic [HALF_W-1:0]               rd_data,
    output logic [HALF_W-1:0]               shadow,
    output logic [NUM_SLOTS-1:0]            arrive,
    output logic [NUM_SLOTS-1:0][CNT_W-1:0] cap_b,
    output logic [NUM_SLOTS-1:0]            cap_done
);
    logic [NUM_SLOTS-1:0] tgl_prev;
    logic [CNT_W-1:0]     copy_q [NUM_SLOTS];
    logic [CNT_W-1:0]     sel_word;

    assign arrive   = tgl_s ^ tgl_prev;
    assign sel_word = rd_slot ? cap_b[1] : cap_b[0];

    // Latch the arm config and flip the arm toggle toward the timer domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_sel    <= EDGE_NONE;
            cfg_second <= 1'b0;
            arm_tgl    <= 1'b0;
        end else if (arm) begin
            cfg_sel    <= edge_sel_e'(arm_sel_in);
            cfg_second <= arm_second_in;
            arm_tgl    <= ~arm_tgl;
        end
    end

    // Track toggles and done flags; an arm pulse clears the flags first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgl_prev <= '0;
            cap_done <= '0;
        end else begin
            tgl_prev <= tgl_s;
            cap_done <= arm ? '0 : (cap_done | arrive);
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        // Copy the slot's timer-side value only when its toggle arrives.
        always_ff @(posedge clk) begin
            if (!rst_n)         copy_q[g] <= '0;
            else if (arrive[g]) copy_q[g] <= cap_t[g];
        end
        assign cap_b[g] = copy_q[g];
    end

    // Low-half reads also latch the upper half; high-half reads return that latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            shadow  <= '0;
        end else if (rd_en) begin
            if (rd_hi) begin
                rd_data <= shadow;
            end else begin
                rd_data <= sel_word[HALF_W-1:0];
                shadow  <= sel_word[CNT_W-1:HALF_W];
            end
        end
    end
endmodule

// File: rtl/dual_capture_timer.sv
// Top: dual-slot input capture with an asynchronous bus-side read path.
// Assumes: tmr_clk is no faster than bus_clk; arm pulses are spaced several timer cycles apart.
module dual_capture_timer
    import dct_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int HALF_W = CNT_W / 2
) (
    input  logic              tmr_clk,
    input  logic              tmr_rst_n,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              evt_in,
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              arm,
    input  logic [1:0]        arm_edge_sel,
    input  logic              arm_second,
    input  logic              rd_en,
    input  logic              rd_slot,
    input  logic              rd_hi,
    output logic [HALF_W-1:0] rd_data,
    output logic [NUM_SLOTS-1:0] cap_done
);
    edge_sel_e                       t_sel;
    slot_state_e                     t_state;
    logic                            t_hit;
    logic                            t_arm_edge;
    logic                            t_arm_s;
    logic [NUM_SLOTS-1:0]            t_tgl;
    logic [NUM_SLOTS-1:0][CNT_W-1:0] t_cap;

    edge_sel_e                       b_cfg_sel;
    logic                            b_cfg_second;
    logic                            b_arm_tgl;
    logic [NUM_SLOTS-1:0]            b_tgl_s;
    logic [NUM_SLOTS-1:0]            b_arrive;
    logic [NUM_SLOTS-1:0][CNT_W-1:0] b_cap;
    logic [HALF_W-1:0]               b_shadow;

    dct_edge_detect u_edge (
        .clk    (tmr_clk),
        .rst_n  (tmr_rst_n),
        .evt_in (evt_in),
        .sel    (t_sel),
        .hit    (t_hit)
    );

    dct_sync2 #(.W(1)) u_arm_sync (
        .clk   (tmr_clk),
        .rst_n (tmr_rst_n),
        .d     (b_arm_tgl),
        .q     (t_arm_s)
    );

    dct_capture_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (tmr_clk),
        .rst_n      (tmr_rst_n),
        .hit        (t_hit),
        .cnt_val    (cnt_val),
        .arm_tgl_s  (t_arm_s),
        .arm_sel    (b_cfg_sel),
        .arm_second (b_cfg_second),
        .sel_q      (t_sel),
        .state_q    (t_state),
        .arm_edge   (t_arm_edge),
        .cap_tgl    (t_tgl),
        .cap_val    (t_cap)
    );

    dct_sync2 #(.W(NUM_SLOTS)) u_cap_sync (
        .clk   (bus_clk),
        .rst_n (bus_rst_n),
        .d     (t_tgl),
        .q     (b_tgl_s)
    );

    dct_bus_regs #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_bus (
        .clk           (bus_clk),
        .rst_n         (bus_rst_n),
        .arm           (arm),
        .arm_sel_in    (arm_edge_sel),
        .arm_second_in (arm_second),
        .cfg_sel       (b_cfg_sel),
        .cfg_second    (b_cfg_second),
        .arm_tgl       (b_arm_tgl),
        .tgl_s         (b_tgl_s),
        .cap_t         (t_cap),
        .rd_en         (rd_en),
        .rd_slot       (rd_slot),
        .rd_hi         (rd_hi),
        .rd_data       (rd_data),
        .shadow        (b_shadow),
        .arrive        (b_arrive),
        .cap_b         (b_cap),
        .cap_done      (cap_done)
    );
endmodule

// File: rtl/dct_checker.sv
// Protocol checker for dual_capture_timer, attached by bind.
// Assumes: both resets are active-low and synchronous to their own clocks.
module dct_checker
    import dct_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int HALF_W = CNT_W / 2
) (
    input logic                            tmr_clk,
    input logic                            tmr_rst_n,
    input logic                            bus_clk,
    input logic                            bus_rst_n,
    input slot_state_e                     t_state,
    input logic                            t_arm_edge,
    input logic [NUM_SLOTS-1:0][CNT_W-1:0] t_cap,
    input logic [NUM_SLOTS-1:0]            b_arrive,
    input logic [NUM_SLOTS-1:0][CNT_W-1:0] b_cap,
    input logic [HALF_W-1:0]               b_shadow,
    input logic                            arm,
    input logic                            rd_en,
    input logic                            rd_hi,
    input logic [NUM_SLOTS-1:0]            cap_done
);
    // R8
    done_hold_chk: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
        (t_state == SLOT_DONE && !t_arm_edge) |=> ($stable(t_cap[0]) && $stable(t_cap[1])));

    // R2
    idle_hold_chk: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
        (t_state == SLOT_IDLE && !t_arm_edge) |=> (t_state == SLOT_IDLE && $stable(t_cap[0])));

    // R12
    copy0_stable_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        !b_arrive[0] |=> $stable(b_cap[0]));

    // R12
    copy1_stable_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        !b_arrive[1] |=> $stable(b_cap[1]));

    // R11
    shadow_hold_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        !(rd_en && !rd_hi) |=> $stable(b_shadow));

    // R9
    done_rise_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        $rose(cap_done[0]) |-> $past(b_arrive[0]));

    // R9
    arm_clear_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        arm |=> (cap_done == '0));
endmodule

bind dual_capture_timer dct_checker #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_chk (
    .tmr_clk    (tmr_clk),
    .tmr_rst_n  (tmr_rst_n),
    .bus_clk    (bus_clk),
    .bus_rst_n  (bus_rst_n),
    .t_state    (t_state),
    .t_arm_edge (t_arm_edge),
    .t_cap      (t_cap),
    .b_arrive   (b_arrive),
    .b_cap      (b_cap),
    .b_shadow   (b_shadow),
    .arm        (arm),
    .rd_en      (rd_en),
    .rd_hi      (rd_hi),
    .cap_done   (cap_done)
);

// File: tb/tb_dual_capture_timer.sv
module tb_dual_capture_timer;
    logic        bus_clk = 1'b0;
    logic        tmr_clk = 1'b0;
    logic        tmr_rst_n = 1'b0;
    logic        bus_rst_n = 1'b0;
    logic [31:0] cnt_val = 32'h0001_0000;
    logic        evt_in = 1'b0;
    logic        arm = 1'b0;
    logic [1:0]  arm_edge_sel = 2'b00;
    logic        arm_second = 1'b0;
    logic        rd_en = 1'b0;
    logic        rd_slot = 1'b0;
    logic        rd_hi = 1'b0;
    logic [15:0] rd_data;
    logic [1:0]  cap_done;

    int checks = 0;
    int fails = 0;
    bit ended = 0;

    // Reference model state (behavioural).
    int          m_state = 0;      // 0 unarmed, 1 first, 2 second, 3 locked
    logic [1:0]  m_sel = 2'b00;
    bit          m_sec = 0;
    logic [31:0] m_cap [2] = '{32'h0, 32'h0};
    logic [1:0]  m_done = 2'b00;
    logic        e1 = 0, e2 = 0, e3 = 0;

    always #5 bus_clk = ~bus_clk;   // 100 MHz bus clock
    always #7 tmr_clk = ~tmr_clk;   // slower, unrelated timer clock

    dual_capture_timer dut (
        .tmr_clk(tmr_clk), .tmr_rst_n(tmr_rst_n), .cnt_val(cnt_val), .evt_in(evt_in),
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .arm(arm), .arm_edge_sel(arm_edge_sel),
        .arm_second(arm_second), .rd_en(rd_en), .rd_slot(rd_slot), .rd_hi(rd_hi),
        .rd_data(rd_data), .cap_done(cap_done)
    );

    // Counter stimulus: changes away from the sampling edge, upper half moves every cycle.
    always @(negedge tmr_clk) cnt_val <= cnt_val + 32'h0003_1357;

    // Model: an edge seen at the input is acted on at the third timer edge.
    always @(posedge tmr_clk) begin
        if (!tmr_rst_n) begin
            e1 = 0; e2 = 0; e3 = 0;
        end else begin
            if (((m_sel[0] && e2 && !e3) || (m_sel[1] && !e2 && e3)) && (m_state == 1 || m_state == 2)) begin
                m_cap[m_state - 1] = cnt_val;
                m_done[m_state - 1] = 1'b1;
                m_state = (m_state == 1 && m_sec) ? 2 : 3;
            end
            e3 = e2; e2 = e1; e1 = evt_in;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    task automatic bus_wait(input int n);
        repeat (n) @(negedge bus_clk);
    endtask

    task automatic set_evt(input logic v);
        @(negedge tmr_clk) evt_in = v;
        repeat (8) @(negedge tmr_clk);
        bus_wait(4);
    endtask

    task automatic do_arm(input logic [1:0] sel, input bit sec);
        @(negedge bus_clk);
        arm = 1; arm_edge_sel = sel; arm_second = sec;
        m_state = 1; m_sel = sel; m_sec = sec; m_done = 2'b00;
        @(negedge bus_clk);
        arm = 0;
        bus_wait(10);
    endtask

    task automatic rd16(input logic slot, input logic hi, output logic [15:0] val);
        @(negedge bus_clk);
        rd_en = 1; rd_slot = slot; rd_hi = hi;
        @(negedge bus_clk);
        rd_en = 0;
        val = rd_data;
    endtask

    task automatic rd32(input logic slot, output logic [31:0] val);
        logic [15:0] lo, hi;
        rd16(slot, 1'b0, lo);
        rd16(slot, 1'b1, hi);
        val = {hi, lo};
    endtask

    initial begin
        #3_000_000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [15:0] h;
        logic [31:0] old0;
        repeat (4) @(negedge bus_clk);
        tmr_rst_n = 1; bus_rst_n = 1;
        bus_wait(3);

        // R1: reset state
        check("R1 done", {30'b0, cap_done}, 32'h0);
        check("R1 rd_data", {16'b0, rd_data}, 32'h0);
        rd32(1'b0, v); check("R1 slot0", v, 32'h0);
        rd32(1'b1, v); check("R1 slot1", v, 32'h0);

        // R2: events before any arm are ignored
        set_evt(1); set_evt(0);
        check("R2 unarmed done", {30'b0, cap_done}, 32'h0);
        rd32(1'b0, v); check("R2 unarmed slot0", v, 32'h0);

        // R2: armed with selection 00 captures nothing
        do_arm(2'b00, 1'b1);
        set_evt(1); set_evt(0);
        check("R2 none done", {30'b0, cap_done}, 32'h0);

        // R3, R6, R7, R8: rising only, second slot disabled
        do_arm(2'b01, 1'b0);
        set_evt(1);
        check("R9 rise done", {30'b0, cap_done}, {30'b0, m_done});
        rd32(1'b0, v); check("R6 rise slot0", v, m_cap[0]);
        old0 = m_cap[0];
        set_evt(0); set_evt(1);
        rd32(1'b0, v); check("R8 locked slot0", v, old0);
        rd32(1'b1, v); check("R7 slot1 untouched", v, 32'h0);
        check("R8 locked done", {30'b0, cap_done}, 32'h1);

        // R9: arm clears done flags
        do_arm(2'b10, 1'b1);
        check("R9 arm clears", {30'b0, cap_done}, 32'h0);

        // R4, R7: falling only, second slot enabled; rising edge in between ignored
        set_evt(0); set_evt(1); set_evt(0);
        check("R4 fall done", {30'b0, cap_done}, 32'h3);
        rd32(1'b0, v); check("R4 fall slot0", v, m_cap[0]);
        rd32(1'b1, v); check("R7 fall slot1", v, m_cap[1]);

        // R5: both edges
        do_arm(2'b11, 1'b1);
        set_evt(1); set_evt(0);
        rd32(1'b0, v); check("R5 both slot0", v, m_cap[0]);
        rd32(1'b1, v); check("R5 both slot1", v, m_cap[1]);
        check("R5 both done", {30'b0, cap_done}, 32'h3);

        // R10, R11: capture between low and high read keeps halves coherent
        do_arm(2'b01, 1'b0);
        set_evt(1);
        old0 = m_cap[0];
        rd16(1'b0, 1'b0, h); check("R10 low half", {16'b0, h}, {16'b0, old0[15:0]});
        set_evt(0);
        do_arm(2'b01, 1'b0);
        set_evt(1);
        rd16(1'b0, 1'b1, h); check("R11 shadow high", {16'b0, h}, {16'b0, old0[31:16]});
        check("R11 new differs", {31'b0, (m_cap[0][31:16] != old0[31:16])}, 32'h1);
        rd32(1'b0, v); check("R10 fresh read", v, m_cap[0]);

        bus_wait(5);
        finish_run();
    end
endmodule